// File: doc/BRIEF.md
# User-Level Interrupt CSR Unit

This block holds the user-mode interrupt and trap state for one hart. It keeps the user status bits, the user interrupt-pending and interrupt-enable sets, and the user scratch, trap-vector, exception-PC, cause and trap-value registers. Instruction decode reaches these registers through a register read/write port with a three-bit select. Interrupt lines from outside set or drive the pending bits.

When the pipeline takes a trap into the user handler, it pulses `trap_i` with the cause, PC and trap value. The unit saves them and pushes the enable bit onto a one-level stack. A return pulse on `uret_i` pops that stack and presents the saved PC on `ret_pc_o`. On the following edge the unit clears the per-trap registers. `irq_o` asks the core to take a user interrupt, and `tvec_o` gives the handler address.

Top module: `uirq_csr_unit`

## Requirements
- R1: While `rst_n` is low, every register reads zero and `irq_o` is 0.
- R2: The status register (select 0) holds the global enable bit at bit 0 and the previous-enable bit at bit 4. All other bits read zero. A write loads both bits from `csr_wdata`.
- R3: A pulse on `trap_i` has the following effect on the next edge. The previous-enable bit takes the old global enable. The global enable clears. The exception PC (select 5) takes `trap_epc_i` with bit 0 forced to 0. The cause register (select 6) takes `trap_is_irq_i` in bit XLEN-1 and `trap_code_i` in its low CODE_W bits, with zeros between. The trap-value register (select 7) takes `trap_tval_i`.
- R4: When `uret_i` is high, `ret_pc_o` shows the stored exception PC. On the next edge the global enable takes the previous-enable bit and the previous-enable bit becomes 1. In the same update the exception PC, cause and trap value all return to zero.
- R5: The pending register (select 2) shows the software bit at bit 0, `tmr_irq_i` at bit 4 and `ext_irq_i` at bit 8. All other bits read zero. Only bit 0 can be written: 1 raises it and 0 clears it. A pulse on `sw_irq_i` sets it, and this set wins over a write in the same cycle. Writes have no effect on bits 4 and 8.
- R6: The enable register (select 1) stores bits 0, 4 and 8 from a write. All other bits read zero.
- R7: `irq_o` is 1 exactly when the global enable is set and at least one interrupt type is both pending and enabled.
- R8: Bit 0 of the exception PC always reads 0, including after a register write that sets it.
- R9: A trap in the same cycle as a register write takes priority for every register both of them update. A trap also takes priority over a return pulse in the same cycle. A return takes priority over a register write.
- R10: The scratch register (select 3) and the trap-vector register (select 4) store full-width writes. `tvec_o` always equals the trap-vector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register select (0 status, 1 enable, 2 pending, 3 scratch, 4 vector, 5 epc, 6 cause, 7 tval) |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the selected register |
| sw_irq_i | input | 1 | Pulse that raises the software-pending bit |
| tmr_irq_i | input | 1 | Timer interrupt level |
| ext_irq_i | input | 1 | External interrupt level |
| trap_i | input | 1 | Trap-taken strobe |
| trap_is_irq_i | input | 1 | Trap was caused by an interrupt |
| trap_code_i | input | CODE_W | Trap cause code |
| trap_epc_i | input | XLEN | PC of the trapped instruction |
| trap_tval_i | input | XLEN | Trap value |
| uret_i | input | 1 | Return-from-user-trap strobe |
| ret_pc_o | output | XLEN | Return PC (stored exception PC) |
| irq_o | output | 1 | User interrupt request |
| tvec_o | output | XLEN | Trap-vector register value |

## Verification
The bench builds the unit with XLEN=32 and CODE_W=5. With these values the cause flag sits at bit 31, the code fills bits 4:0, and the reserved gap lies between them, so the reads can show a stray bit in that gap. A 32-bit width also keeps bits above 8 in play in the pending and enable registers, so leaked reserved bits are visible. Random traffic often puts a trap, a return and a write in the same cycle, which exercises every priority order of R9.

// File: rtl/uirq_csr_unit.sv
module uirq_csr_unit #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [2:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              sw_irq_i,
  input  logic              tmr_irq_i,
  input  logic              ext_irq_i,
  input  logic              trap_i,
  input  logic              trap_is_irq_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic [XLEN-1:0]   trap_epc_i,
  input  logic [XLEN-1:0]   trap_tval_i,
  input  logic              uret_i,
  output logic [XLEN-1:0]   ret_pc_o,
  output logic              irq_o,
  output logic [XLEN-1:0]   tvec_o
);
  localparam logic [2:0] SEL_STAT = 3'd0, SEL_EN = 3'd1, SEL_PEND = 3'd2, SEL_SCR = 3'd3,
                         SEL_VEC = 3'd4, SEL_EPC = 3'd5, SEL_CAUSE = 3'd6, SEL_TVAL = 3'd7;
  localparam int GAP_W = XLEN - 1 - CODE_W;

  logic            ie_q, pie_q, swp_q;
  logic [2:0]      en_q;
  logic [XLEN-1:0] scr_q, vec_q, epc_q, cause_q, tval_q;
  logic [2:0]      pend;

  function automatic logic [XLEN-1:0] spread(input logic [2:0] b);
    logic [XLEN-1:0] v;
    v = '0;
    v[0] = b[0];
    v[4] = b[1];
    v[8] = b[2];
    return v;
  endfunction

  wire wr_stat  = csr_we && csr_sel == SEL_STAT;
  wire wr_en    = csr_we && csr_sel == SEL_EN;
  wire wr_pend  = csr_we && csr_sel == SEL_PEND;
  wire wr_scr   = csr_we && csr_sel == SEL_SCR;
  wire wr_vec   = csr_we && csr_sel == SEL_VEC;
  wire wr_epc   = csr_we && csr_sel == SEL_EPC;
  wire wr_cause = csr_we && csr_sel == SEL_CAUSE;
  wire wr_tval  = csr_we && csr_sel == SEL_TVAL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      pie_q <= 1'b0;
    end else if (trap_i) begin
      pie_q <= ie_q;
      ie_q  <= 1'b0;
    end else if (uret_i) begin
      ie_q  <= pie_q;
      pie_q <= 1'b1;
    end else if (wr_stat) begin
      ie_q  <= csr_wdata[0];
      pie_q <= csr_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swp_q <= 1'b0;
      en_q  <= '0;
      scr_q <= '0;
      vec_q <= '0;
    end else begin
      if (sw_irq_i)     swp_q <= 1'b1;
      else if (wr_pend) swp_q <= csr_wdata[0];
      if (wr_en)  en_q  <= {csr_wdata[8], csr_wdata[4], csr_wdata[0]};
      if (wr_scr) scr_q <= csr_wdata;
      if (wr_vec) vec_q <= csr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (trap_i) begin
      epc_q   <= {trap_epc_i[XLEN-1:1], 1'b0};
      cause_q <= {trap_is_irq_i, {GAP_W{1'b0}}, trap_code_i};
      tval_q  <= trap_tval_i;
    end else if (uret_i) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else begin
      if (wr_epc)   epc_q   <= {csr_wdata[XLEN-1:1], 1'b0};
      if (wr_cause) cause_q <= csr_wdata;
      if (wr_tval)  tval_q  <= csr_wdata;
    end
  end

  assign pend = {ext_irq_i, tmr_irq_i, swp_q};

  always_comb begin
    unique case (csr_sel)
      SEL_STAT:  csr_rdata = spread({1'b0, pie_q, ie_q});
      SEL_EN:    csr_rdata = spread(en_q);
      SEL_PEND:  csr_rdata = spread(pend);
      SEL_SCR:   csr_rdata = scr_q;
      SEL_VEC:   csr_rdata = vec_q;
      SEL_EPC:   csr_rdata = epc_q;
      SEL_CAUSE: csr_rdata = cause_q;
      default:   csr_rdata = tval_q;
    endcase
  end

  assign irq_o    = ie_q & |(pend & en_q);
  assign ret_pc_o = epc_q;
  assign tvec_o   = vec_q;
endmodule

module uirq_csr_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_i,
  input logic            uret_i,
  input logic            csr_we,
  input logic [2:0]      csr_sel,
  input logic [XLEN-1:0] csr_wdata,
  input logic            ie_q,
  input logic            pie_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] cause_q,
  input logic [XLEN-1:0] tval_q,
  input logic [XLEN-1:0] ret_pc_o,
  input logic            irq_o
);
  p_trap_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (!ie_q && pie_q == $past(ie_q)));
  p_ret_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uret_i && !trap_i) |=> (pie_q && ie_q == $past(pie_q)));
  p_ret_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uret_i && !trap_i) |=> (epc_q == '0 && cause_q == '0 && tval_q == '0));
  p_no_irq_after_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> !irq_o);
  p_epc_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pc_o[0] == 1'b0);
  p_stat_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 3'd0 && !trap_i && !uret_i) |=> (pie_q == $past(csr_wdata[4])));
  p_trap_beats_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && csr_we && csr_sel == 3'd0) |=> !ie_q);
endmodule

bind uirq_csr_unit uirq_csr_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .uret_i(uret_i),
  .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
  .ie_q(ie_q), .pie_q(pie_q), .epc_q(epc_q), .cause_q(cause_q), .tval_q(tval_q),
  .ret_pc_o(ret_pc_o), .irq_o(irq_o)
);

// File: tb/uirq_csr_unit_tb_top.sv
`timescale 1ns/1ps
module uirq_csr_unit_tb_top;
  localparam int XLEN = 32;
  localparam int CODE_W = 5;

  logic clk = 0, rst_n = 0;
  logic csr_we = 0, sw_irq = 0, tmr_irq = 0, ext_irq = 0, trap = 0, trap_irq = 0, uret = 0;
  logic [2:0] csr_sel = 0;
  logic [XLEN-1:0] wdata = 0, t_epc = 0, t_tval = 0;
  logic [CODE_W-1:0] t_code = 0;
  logic [XLEN-1:0] rdata, ret_pc, tvec;
  logic irq;

  int checks = 0, errors = 0;
  bit m_ie, m_pie, m_sw;
  bit [2:0] m_en;
  logic [XLEN-1:0] m_scr, m_vec, m_epc, m_cause, m_tval;

  always #10 clk = ~clk;

  uirq_csr_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(wdata),
    .csr_rdata(rdata), .sw_irq_i(sw_irq), .tmr_irq_i(tmr_irq), .ext_irq_i(ext_irq),
    .trap_i(trap), .trap_is_irq_i(trap_irq), .trap_code_i(t_code), .trap_epc_i(t_epc),
    .trap_tval_i(t_tval), .uret_i(uret), .ret_pc_o(ret_pc), .irq_o(irq), .tvec_o(tvec));

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] spread(bit [2:0] b);
    logic [XLEN-1:0] v = '0;
    v[0] = b[0]; v[4] = b[1]; v[8] = b[2];
    return v;
  endfunction

  function automatic logic [XLEN-1:0] exp_rd(logic [2:0] s);
    case (s)
      3'd0: return spread({1'b0, m_pie, m_ie});
      3'd1: return spread(m_en);
      3'd2: return spread({ext_irq, tmr_irq, m_sw});
      3'd3: return m_scr;
      3'd4: return m_vec;
      3'd5: return m_epc;
      3'd6: return m_cause;
      default: return m_tval;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] s);
    case (s)
      3'd0: return "R2 status";
      3'd1: return "R6 enable";
      3'd2: return "R5 pending";
      3'd3, 3'd4: return "R10 scratch/vector";
      3'd5: return "R8 epc";
      default: return "R3 cause/tval";
    endcase
  endfunction

  task automatic model_update();
    bit nsw = sw_irq ? 1'b1 : ((csr_we && csr_sel == 2) ? wdata[0] : m_sw);
    if (csr_we && csr_sel == 1) m_en = {wdata[8], wdata[4], wdata[0]};
    if (csr_we && csr_sel == 3) m_scr = wdata;
    if (csr_we && csr_sel == 4) m_vec = wdata;
    m_sw = nsw;
    if (trap) begin
      m_pie = m_ie; m_ie = 0;
      m_epc = {t_epc[XLEN-1:1], 1'b0};
      m_cause = '0; m_cause[XLEN-1] = trap_irq; m_cause[CODE_W-1:0] = t_code;
      m_tval = t_tval;
    end else if (uret) begin
      m_ie = m_pie; m_pie = 1;
      m_epc = '0; m_cause = '0; m_tval = '0;
    end else if (csr_we) begin
      case (csr_sel)
        3'd0: begin m_ie = wdata[0]; m_pie = wdata[4]; end
        3'd5: m_epc = {wdata[XLEN-1:1], 1'b0};
        3'd6: m_cause = wdata;
        3'd7: m_tval = wdata;
        default: ;
      endcase
    end
  endtask

  task automatic cycle();
    #1;
    chk(req_of(csr_sel), rdata, exp_rd(csr_sel));
    chk("R7 irq", {31'b0, irq}, {31'b0, m_ie & |({ext_irq, tmr_irq, m_sw} & m_en)});
    chk("R4 ret_pc", ret_pc, m_epc);
    chk("R10 tvec", tvec, m_vec);
    @(posedge clk);
    model_update();
    @(negedge clk);
    {csr_we, sw_irq, trap, trap_irq, uret} = '0;
  endtask

  task automatic idle_read(logic [2:0] s);
    csr_sel = s; csr_we = 0; #1;
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    m_ie = 0; m_pie = 0; m_sw = 0; m_en = 0;
    m_scr = 0; m_vec = 0; m_epc = 0; m_cause = 0; m_tval = 0;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      csr_sel = 3'(s); #1;
      chk("R1 reset read", rdata, '0);
    end
    chk("R1 reset irq", {31'b0, irq}, '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    csr_we = 1; csr_sel = 0; wdata = '1; cycle();
    idle_read(0); chk("R2 status layout", rdata, 32'h11);
    csr_we = 1; csr_sel = 1; wdata = '1; cycle();
    idle_read(1); chk("R6 enable layout", rdata, 32'h111);
    csr_we = 1; csr_sel = 2; wdata = '1; cycle();
    idle_read(2); chk("R5 only sw bit writable", rdata, 32'h1);
    chk("R7 irq on sw", {31'b0, irq}, 32'h1);
    csr_we = 1; csr_sel = 5; wdata = 32'h0000_0FFF; cycle();
    idle_read(5); chk("R8 epc bit0 ignored", rdata, 32'h0000_0FFE);
    csr_we = 1; csr_sel = 2; wdata = 0; sw_irq = 1; cycle();
    idle_read(2); chk("R5 set wins over clear", rdata, 32'h1);
    trap = 1; trap_irq = 1; t_code = 5'd7; t_epc = 32'h1003; t_tval = 32'hABC;
    csr_we = 1; csr_sel = 0; wdata = '1; uret = 1; cycle();
    idle_read(0); chk("R9 trap beats write/ret", rdata, 32'h10);
    idle_read(6); chk("R3 cause format", rdata, 32'h8000_0007);
    chk("R3 irq masked after trap", {31'b0, irq}, 32'h0);
    idle_read(0); uret = 1; #1;
    chk("R4 ret pc", ret_pc, 32'h1002);
    cycle();
    idle_read(0); chk("R4 pop", rdata, 32'h11);
    idle_read(5); chk("R4 epc cleared", rdata, 32'h0);
    idle_read(7); chk("R4 tval cleared", rdata, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      csr_sel  = 3'($urandom_range(0, 7));
      csr_we   = ($urandom_range(0, 9) < 4);
      wdata    = $urandom();
      sw_irq   = ($urandom_range(0, 9) == 0);
      tmr_irq  = $urandom_range(0, 1);
      ext_irq  = $urandom_range(0, 1);
      trap     = ($urandom_range(0, 9) == 0);
      trap_irq = $urandom_range(0, 1);
      t_code   = 5'($urandom());
      t_epc    = $urandom();
      t_tval   = $urandom();
      uret     = ($urandom_range(0, 9) == 0);
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule